// File: doc/BRIEF.md
# Program Counter Sequencer with Halt and Interrupt Return

This block produces the next instruction address for a single-cycle processor with 16-bit data and an 11-bit program counter. On every clock it loads the program counter from one of four sources, chosen by a two-bit select. The sources are the incremented PC, the low bits of the working register, an instruction literal, and a value derived from a dedicated save register. A skip input makes the increment path step by two, so that one instruction is bypassed after a conditional test.

The save strobe comes from the halt instruction. It copies the current PC into the save register and parks the core. While parked, the PC holds its value and the select, skip and save inputs have no effect. A rising edge on the interrupt request releases the core on the next clock, and execution resumes at the instruction after the halt. The return-from-interrupt source reloads the PC with the saved address plus two. All address arithmetic wraps modulo 2^11.

Top module: `pc_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0, clears the save register to 0 and leaves the core running.
- R2: While running with save low, select 0 and skip low, the PC advances by one on the next clock.
- R3: While running with save low and select 0, skip high makes the PC advance by two. Skip has no effect for selects 1, 2 and 3.
- R4: While running with save low, select 1 loads the PC from bits 10:0 of the working-register input.
- R5: While running with save low, select 2 loads the PC from the 11-bit literal input.
- R6: While running with save low, select 3 loads the PC with the save register plus two (return from interrupt).
- R7: While running, save high copies the current PC into the save register and enters the halted state. The PC keeps its value on that clock, whatever the select and skip inputs are.
- R8: While halted, the PC holds and the select, skip and save inputs are ignored. An interrupt request that is held high with no rising edge does not release the halt.
- R9: While halted, a rising edge on the interrupt request (low on the previous clock, high on this one) releases the halt. On the next clock the PC becomes the save register plus one. A rising edge while running has no effect.
- R10: Every PC sum wraps modulo 2^11. For example, 0x7FF plus one gives 0x000, and 0x7FE plus two gives 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_sel | input | 2 | Next-PC source: 0 increment, 1 working register, 2 literal, 3 saved+2 |
| skip | input | 1 | Increment by two instead of one (select 0 only) |
| save | input | 1 | Halt strobe: capture the PC and stop |
| irq | input | 1 | Interrupt request; a rising edge wakes a halted core |
| w_data | input | 16 | Working-register value; the low 11 bits are the jump target |
| lit | input | 11 | Instruction literal jump target |
| pc | output | 11 | Registered program counter |

## Verification
Directed sequences run each source in isolation. Each one compares against a target that differs from every other source's result, so a swapped select decode shows up as a wrong address. Addresses near 0x7FF exercise the wrap, and separate one-step and two-step cases tell the skip path apart from plain increment. The halt cases cover several conditions: a request held high across the halt, which must not wake the core; a later rising edge, which must wake it; and select, skip and save activity while parked, which must be ignored. A seeded random run then mixes all sources, strobes and interrupt levels, and each step is compared against a cycle model in the bench.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  typedef enum logic [1:0] {
    PC_SRC_INCR  = 2'd0,
    PC_SRC_WREG  = 2'd1,
    PC_SRC_LIT   = 2'd2,
    PC_SRC_RETRN = 2'd3
  } pc_src_e;

  localparam int unsigned STEP_W = 2;
endpackage

// File: rtl/pc_offset_add.sv
module pc_offset_add #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        offset,
  output logic [ADDR_W-1:0] sum
);
  localparam int unsigned PAD_W = ADDR_W - 2;
  // Sum truncated to ADDR_W bits: modular wrap
  assign sum = base + {{PAD_W{1'b0}}, offset};
endmodule

// File: rtl/pc_save_reg.sv
module pc_save_reg #(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (capture) q <= d;
  end
endmodule

// File: rtl/pc_halt_ctrl.sv
module pc_halt_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic halt_req,
  input  logic irq,
  output logic halted,
  output logic irq_q,
  output logic wake
);
  assign wake = halted & irq & ~irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= irq;
      if (wake)          halted <= 1'b0;
      else if (halt_req) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        pc_sel,
  input  logic              skip,
  input  logic              save,
  input  logic              irq,
  input  logic [DATA_W-1:0] w_data,
  input  logic [ADDR_W-1:0] lit,
  output logic [ADDR_W-1:0] pc
);
  import pc_seq_pkg::*;

  logic [ADDR_W-1:0] save_pc;
  logic [ADDR_W-1:0] incr_pc;
  logic [ADDR_W-1:0] ret_pc;
  logic [ADDR_W-1:0] resume_pc;
  logic [ADDR_W-1:0] mux_pc;
  logic              halted;
  logic              irq_q;
  logic              wake;
  logic              halt_req;
  pc_src_e           src;

  assign src      = pc_src_e'(pc_sel);
  assign halt_req = ~halted & save;

  pc_offset_add #(.ADDR_W(ADDR_W)) u_incr (
    .base(pc), .offset(skip ? 2'd2 : 2'd1), .sum(incr_pc));
  pc_offset_add #(.ADDR_W(ADDR_W)) u_ret (
    .base(save_pc), .offset(2'd2), .sum(ret_pc));
  pc_offset_add #(.ADDR_W(ADDR_W)) u_resume (
    .base(save_pc), .offset(2'd1), .sum(resume_pc));

  pc_save_reg #(.ADDR_W(ADDR_W)) u_save (
    .clk(clk), .rst(rst), .capture(halt_req), .d(pc), .q(save_pc));

  pc_halt_ctrl u_halt (
    .clk(clk), .rst(rst), .halt_req(halt_req), .irq(irq),
    .halted(halted), .irq_q(irq_q), .wake(wake));

  always_comb begin
    unique case (src)
      PC_SRC_INCR:  mux_pc = incr_pc;
      PC_SRC_WREG:  mux_pc = w_data[ADDR_W-1:0];
      PC_SRC_LIT:   mux_pc = lit;
      default:      mux_pc = ret_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)            pc <= '0;
    else if (halted) begin
      if (wake)         pc <= resume_pc;
    end
    else if (!save)     pc <= mux_pc;
  end
endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        pc_sel,
  input logic              skip,
  input logic              save,
  input logic              irq,
  input logic [DATA_W-1:0] w_data,
  input logic [ADDR_W-1:0] lit,
  input logic [ADDR_W-1:0] pc,
  input logic              halted,
  input logic              irq_q,
  input logic [ADDR_W-1:0] save_pc
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc == '0 && save_pc == '0 && !halted));
  // R2
  incr_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && !save && pc_sel == 2'd0 && !skip) |=> pc == $past(pc) + ONE);
  // R3
  incr_two_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && !save && pc_sel == 2'd0 && skip) |=> pc == $past(pc) + TWO);
  // R4
  wreg_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && !save && pc_sel == 2'd1) |=> pc == $past(w_data[ADDR_W-1:0]));
  // R5
  lit_jump_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && !save && pc_sel == 2'd2) |=> pc == $past(lit));
  // R6
  return_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && !save && pc_sel == 2'd3) |=> pc == $past(save_pc) + TWO);
  // R7
  halt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (!halted && save) |=> (halted && $stable(pc) && save_pc == $past(pc)));
  // R8
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && !(irq && !irq_q)) |=> (halted && $stable(pc) && $stable(save_pc)));
  // R9
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    (halted && irq && !irq_q) |=> (!halted && pc == $past(save_pc) + ONE));
endmodule

bind pc_sequencer pc_sequencer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .pc_sel(pc_sel), .skip(skip), .save(save), .irq(irq),
  .w_data(w_data), .lit(lit), .pc(pc), .halted(halted), .irq_q(irq_q),
  .save_pc(save_pc));

// File: tb/pc_sequencer_tb_top.sv
module pc_sequencer_tb_top;
  localparam int unsigned AW = 11;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    pc_sel = '0;
  logic          skip = 1'b0;
  logic          save = 1'b0;
  logic          irq = 1'b0;
  logic [DW-1:0] w_data = '0;
  logic [AW-1:0] lit = '0;
  logic [AW-1:0] pc;

  int n_cmp = 0;
  int n_bad = 0;

  logic [AW-1:0] m_pc = '0;
  logic [AW-1:0] m_saved = '0;
  logic          m_halted = 1'b0;
  logic          m_irq_q = 1'b0;

  pc_sequencer #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .pc_sel(pc_sel), .skip(skip), .save(save),
    .irq(irq), .w_data(w_data), .lit(lit), .pc(pc));

  always #10 clk = ~clk;

  function automatic string tag_of(logic h, logic rise, logic sv, logic [1:0] s, logic sk);
    if (h) return rise ? "R9" : "R8";
    if (sv) return "R7";
    case (s)
      2'd0: return sk ? "R3" : "R2";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [AW-1:0] f_next(logic [AW-1:0] p, logic [AW-1:0] sv_pc,
                                           logic [1:0] s, logic sk,
                                           logic [DW-1:0] w, logic [AW-1:0] l);
    case (s)
      2'd0: return p + (sk ? AW'(2) : AW'(1));
      2'd1: return w[AW-1:0];
      2'd2: return l;
      default: return sv_pc + AW'(2);
    endcase
  endfunction

  task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: pc actual 0x%03h expected 0x%03h", tag, act, exp);
    end
  endtask

  task automatic step(logic [1:0] s, logic sk, logic sv, logic iq,
                      logic [DW-1:0] w, logic [AW-1:0] l, string force_tag);
    logic rise;
    string tag;
    pc_sel = s; skip = sk; save = sv; irq = iq; w_data = w; lit = l;
    rise = iq & ~m_irq_q;
    tag = (force_tag != "") ? force_tag : tag_of(m_halted, rise, sv, s, sk);
    @(posedge clk);
    if (m_halted) begin
      if (rise) begin
        m_pc = m_saved + AW'(1);
        m_halted = 1'b0;
      end
    end else if (sv) begin
      m_saved = m_pc;
      m_halted = 1'b1;
    end else begin
      m_pc = f_next(m_pc, m_saved, s, sk, w, l);
    end
    m_irq_q = iq;
    #1;
    check(tag, pc, m_pc);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1", pc, '0);
    rst = 1'b0;

    // R1: save register is 0 after reset, so a return lands at 2
    step(2'd3, 1'b0, 1'b0, 1'b0, '0, '0, "R1");
    // R2/R3 plain and skip increments
    step(2'd0, 1'b0, 1'b0, 1'b0, '0, '0, "R2");
    step(2'd0, 1'b1, 1'b0, 1'b0, '0, '0, "R3");
    // R4 working register low bits (upper bits differ)
    step(2'd1, 1'b1, 1'b0, 1'b0, 16'hF123, 11'h055, "R4");
    // R5 literal
    step(2'd2, 1'b1, 1'b0, 1'b0, 16'h0222, 11'h7FF, "R5");
    // R10 wrap of +1 from 0x7FF
    step(2'd0, 1'b0, 1'b0, 1'b0, '0, '0, "R10");
    step(2'd2, 1'b0, 1'b0, 1'b0, '0, 11'h7FE, "R5");
    // R10 wrap of +2 from 0x7FE
    step(2'd0, 1'b1, 1'b0, 1'b0, '0, '0, "R10");
    step(2'd2, 1'b0, 1'b0, 1'b0, '0, 11'h120, "R5");
    // R7 halt with irq already high and a conflicting select
    step(2'd2, 1'b1, 1'b1, 1'b1, '0, 11'h333, "R7");
    // R8 held irq, select/skip/save activity ignored
    step(2'd1, 1'b1, 1'b1, 1'b1, 16'h0444, 11'h555, "R8");
    step(2'd3, 1'b0, 1'b0, 1'b0, '0, '0, "R8");
    step(2'd0, 1'b1, 1'b1, 1'b0, '0, '0, "R8");
    // R9 rising edge wakes at saved+1 = 0x121
    step(2'd2, 1'b0, 1'b1, 1'b1, '0, 11'h666, "R9");
    // R9 rising edge while running has no effect
    step(2'd0, 1'b0, 1'b0, 1'b0, '0, '0, "R2");
    step(2'd0, 1'b0, 1'b0, 1'b1, '0, '0, "R9");
    // R6 return = saved + 2 = 0x122; skip ignored
    step(2'd3, 1'b1, 1'b0, 1'b1, '0, '0, "R6");
    // R10 return wrap: halt at 0x7FF, return gives 0x001
    step(2'd2, 1'b0, 1'b0, 1'b0, '0, 11'h7FF, "R5");
    step(2'd0, 1'b0, 1'b1, 1'b0, '0, '0, "R7");
    step(2'd0, 1'b0, 1'b0, 1'b1, '0, '0, "R9");
    step(2'd3, 1'b0, 1'b0, 1'b0, '0, '0, "R10");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] s;
      logic sk, sv, iq;
      s  = 2'($urandom_range(0, 3));
      sk = 1'($urandom_range(0, 1));
      sv = ($urandom_range(0, 9) == 0);
      iq = ($urandom_range(0, 3) == 0);
      step(s, sk, sv, iq, 16'($urandom), 11'($urandom), "");
    end

    // R1 reset mid-run from a halted state
    step(2'd0, 1'b0, 1'b1, 1'b0, '0, '0, "R7");
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R1", pc, '0);
    rst = 1'b0;
    m_pc = '0; m_saved = '0; m_halted = 1'b0; m_irq_q = 1'b0;
    irq = 1'b0;
    step(2'd0, 1'b0, 1'b0, 1'b0, '0, '0, "R1");
    step(2'd3, 1'b0, 1'b0, 1'b0, '0, '0, "R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule